// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor whose 32 visible registers are taken from a larger physical store through overlapping windows. A window pointer selects the window in use. Two combinational read ports and one clocked write port each take a 5-bit architectural register number. The block turns that number into a physical entry from the number's group and the current pointer.

Registers 0 to 7 are global and the same in every window. Register 0 always reads as zero. Registers 8 to 15 are the window's outputs and 16 to 23 are its locals. Registers 24 to 31 are its inputs, which are stored in the same place as the output registers of the neighbouring window. A caller places arguments in its outputs, opens a new window with a save, and the callee finds them in its inputs without any copy.

Save and restore requests step the pointer in opposite directions. A parameter selects which way a save goes. Before a save or restore moves the pointer, the block checks the target window's bit in an invalid-window mask. If that bit is set, the block raises a spill or fill flag and does not move the pointer. Trap entry and trap return inputs step the pointer in the same way with no mask check.

Top module: `windowed_regfile`

## Requirements
- R1: Register numbers 0 to 7 address the same storage in every window. A value written to global register 1 in one window reads back unchanged in any other window.
- R2: The pointer always stays below NWIN and wraps modulo NWIN. NWIN steps in one direction return it to its starting value.
- R3: Register 0 always reads as 0 on both read ports, and a write to register 0 is discarded.
- R4: Registers 16 to 23 are private to each window. A local written in one window is not changed by writing the same local number in another window.
- R5: After a save, input register 24+k reads the value that output register 8+k held before the save, for k from 0 to 7.
- R6: With SAVE_INC=0, a save decrements the pointer and a restore increments it. With SAVE_INC=1, a save increments the pointer and a restore decrements it. With no step input active, the pointer holds its value.
- R7: If the mask bit of a save's target window is set, spill_flag is 1 in that cycle and the pointer does not change. If the mask bit of a restore's target window is set, fill_flag is 1 in that cycle and the pointer does not change. The two flags are never 1 together.
- R8: trap_enter steps the pointer like a save and trap_return steps it like a restore. Neither checks the mask. Priority runs trap_enter, then trap_return, then save_req, then restore_req. A request with lower priority is ignored and raises no flag.
- R9: A read of the register being written in the same cycle returns the new write data. A write uses the pointer value in effect before any step that happens in the same cycle.
- R10: After reset the pointer is 0 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Read port A register number |
| rd_a_val | output | DW | Read port A data |
| rd_b_idx | input | 5 | Read port B register number |
| rd_b_val | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_val | input | DW | Write data |
| save_req | input | 1 | Open a new window |
| restore_req | input | 1 | Return to the previous window |
| trap_enter | input | 1 | Step like a save, with no mask check |
| trap_return | input | 1 | Step like a restore, with no mask check |
| inval_mask | input | NWIN | One bit per window; a set bit blocks entry by save or restore |
| cwp | output | 5 | Current window pointer |
| spill_flag | output | 1 | A save was blocked by the mask |
| fill_flag | output | 1 | A restore was blocked by the mask |

## Verification
The embedded properties check on every cycle that the pointer stays in range, that register 0 reads as zero, that a blocked step or an idle cycle leaves the pointer unchanged, and that the two flags never appear together. Whether data really passes between windows can only be shown by the bench's scenarios: output-to-input aliasing across a save, local privacy, sharing of the globals and the same-cycle write bypass. Two instances, one per step direction, take the same stimulus, so both directions and both alias mappings are shown side by side. Each instance is compared against a pointer model kept in the bench.

// File: rtl/windowed_regfile.sv
module windowed_regfile #(
  parameter int NWIN     = 8,
  parameter int DW       = 32,
  parameter bit SAVE_INC = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_a_idx,
  output logic [DW-1:0]   rd_a_val,
  input  logic [4:0]      rd_b_idx,
  output logic [DW-1:0]   rd_b_val,
  input  logic            wr_en,
  input  logic [4:0]      wr_idx,
  input  logic [DW-1:0]   wr_val,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            trap_enter,
  input  logic            trap_return,
  input  logic [NWIN-1:0] inval_mask,
  output logic [4:0]      cwp,
  output logic            spill_flag,
  output logic            fill_flag
);
  localparam int NPHYS = 8 + 16 * NWIN;
  localparam int PW    = $clog2(NPHYS);
  localparam int WW    = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam logic [WW-1:0] LAST = WW'(NWIN - 1);

  logic [DW-1:0] store [NPHYS];
  logic [WW-1:0] ptr, ptr_up, ptr_dn, save_tgt, rest_tgt, nb;
  logic          no_trap;

  assign ptr_up   = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign ptr_dn   = (ptr == '0) ? LAST : ptr - 1'b1;
  assign save_tgt = SAVE_INC ? ptr_up : ptr_dn;
  assign rest_tgt = SAVE_INC ? ptr_dn : ptr_up;
  assign nb       = SAVE_INC ? ptr_dn : ptr_up;
  assign no_trap  = !trap_enter && !trap_return;

  assign spill_flag = no_trap && save_req && inval_mask[save_tgt];
  assign fill_flag  = no_trap && !save_req && restore_req && inval_mask[rest_tgt];
  assign cwp        = 5'(ptr);

  function automatic logic [PW-1:0] phys(input logic [4:0] r);
    logic [PW-1:0] own_base, nb_base;
    own_base = PW'(8) + (PW'(ptr) << 4);
    nb_base  = PW'(8) + (PW'(nb) << 4);
    case (r[4:3])
      2'd0:    phys = PW'(r);
      2'd1:    phys = own_base + PW'(r[2:0]);
      2'd2:    phys = own_base + PW'(8) + PW'(r[2:0]);
      default: phys = nb_base + PW'(r[2:0]);
    endcase
  endfunction

  function automatic logic [DW-1:0] rd(input logic [4:0] r);
    if (r == 5'd0)                   rd = '0;
    else if (wr_en && wr_idx == r)   rd = wr_val;
    else                             rd = store[phys(r)];
  endfunction

  assign rd_a_val = rd(rd_a_idx);
  assign rd_b_val = rd(rd_b_idx);

  always_ff @(posedge clk)
    if (wr_en && wr_idx != 5'd0) store[phys(wr_idx)] <= wr_val;

  always_ff @(posedge clk) begin
    if (!rst_n)                                    ptr <= '0;
    else if (trap_enter)                           ptr <= save_tgt;
    else if (trap_return)                          ptr <= rest_tgt;
    else if (save_req && !inval_mask[save_tgt])    ptr <= save_tgt;
    else if (!save_req && restore_req && !inval_mask[rest_tgt]) ptr <= rest_tgt;
  end

  AST_CWP_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cwp < 5'(NWIN)); // R2
  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n) (rd_a_idx == 5'd0) |-> (rd_a_val == '0)); // R3
  AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (spill_flag || fill_flag) |=> $stable(cwp)); // R7
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(spill_flag && fill_flag)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(save_req || restore_req || trap_enter || trap_return) |=> $stable(cwp)); // R6
endmodule

// File: tb/tb_windowed_regfile.sv
module tb_windowed_regfile;
  localparam int CLK_P = 10;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic [4:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] wr_val = 0;
  logic wr_en = 0, save_req = 0, restore_req = 0, trap_enter = 0, trap_return = 0;
  logic [N-1:0] inval_mask = 0;
  logic [31:0] a_d, b_d, a_i, b_i;
  logic [4:0] cwp_d, cwp_i;
  logic sp_d, fl_d, sp_i, fl_i;
  int runs = 0, fails = 0;
  int ed = 0, ei = 0;

  always #(CLK_P/2) clk = ~clk;

  windowed_regfile #(.NWIN(N), .DW(32), .SAVE_INC(1'b0)) dut (
    .clk, .rst_n, .rd_a_idx, .rd_a_val(a_d), .rd_b_idx, .rd_b_val(b_d),
    .wr_en, .wr_idx, .wr_val, .save_req, .restore_req, .trap_enter, .trap_return,
    .inval_mask, .cwp(cwp_d), .spill_flag(sp_d), .fill_flag(fl_d));

  windowed_regfile #(.NWIN(N), .DW(32), .SAVE_INC(1'b1)) dut_inc (
    .clk, .rst_n, .rd_a_idx, .rd_a_val(a_i), .rd_b_idx, .rd_b_val(b_i),
    .wr_en, .wr_idx, .wr_val, .save_req, .restore_req, .trap_enter, .trap_return,
    .inval_mask, .cwp(cwp_i), .spill_flag(sp_i), .fill_flag(fl_i));

  // {idx, write data, expected read}
  localparam logic [68:0] VEC [6] = '{
    {5'd0,  32'hDEAD_0000, 32'h0000_0000},
    {5'd1,  32'h1111_0001, 32'h1111_0001},
    {5'd7,  32'h7777_0007, 32'h7777_0007},
    {5'd10, 32'h0A0A_000A, 32'h0A0A_000A},
    {5'd16, 32'h1616_0010, 32'h1616_0010},
    {5'd24, 32'h2424_0018, 32'h2424_0018}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] v);
    @(negedge clk); wr_en = 1; wr_idx = idx; wr_val = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd2(input logic [4:0] idx, input logic [31:0] ed_v, input logic [31:0] ei_v, input string req);
    @(negedge clk); rd_a_idx = idx; rd_b_idx = idx; #1;
    check(req, a_d, ed_v); check(req, a_i, ei_v);
    check(req, b_d, ed_v); check(req, b_i, ei_v);
  endtask

  function automatic int up(input int c); return (c == N-1) ? 0 : c + 1; endfunction
  function automatic int dn(input int c); return (c == 0) ? N-1 : c - 1; endfunction

  // model step; mode 0: save decrements, mode 1: save increments
  function automatic int nxt(input int c, input bit inc, input bit s, input bit r,
                             input bit te, input bit tr, output bit sp, output bit fl);
    int st, rt;
    st = inc ? up(c) : dn(c);
    rt = inc ? dn(c) : up(c);
    sp = 0; fl = 0;
    if (te) return st;
    if (tr) return rt;
    if (s) begin if (inval_mask[st]) begin sp = 1; return c; end return st; end
    if (r) begin if (inval_mask[rt]) begin fl = 1; return c; end return rt; end
    return c;
  endfunction

  task automatic step(input bit s, input bit r, input bit te, input bit tr, input string req);
    bit spd, fld, spi, fli;
    @(negedge clk);
    save_req = s; restore_req = r; trap_enter = te; trap_return = tr;
    ed = nxt(ed, 1'b0, s, r, te, tr, spd, fld);
    ei = nxt(ei, 1'b1, s, r, te, tr, spi, fli);
    #1;
    check({req, " spill"}, 32'(sp_d), 32'(spd)); check({req, " fill"}, 32'(fl_d), 32'(fld));
    check({req, " spill"}, 32'(sp_i), 32'(spi)); check({req, " fill"}, 32'(fl_i), 32'(fli));
    @(negedge clk);
    save_req = 0; restore_req = 0; trap_enter = 0; trap_return = 0; #1;
    check({req, " cwp"}, 32'(cwp_d), 32'(ed)); check({req, " cwp"}, 32'(cwp_i), 32'(ei));
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    // R10 reset state
    check("R10 cwp", 32'(cwp_d), 0); check("R10 cwp", 32'(cwp_i), 0);
    check("R10 flags", 32'({sp_d, fl_d, sp_i, fl_i}), 0);

    // vector table in window 0: R1 globals, R3 zero register
    for (int k = 0; k < 6; k++) begin
      wr(VEC[k][68:64], VEC[k][63:32]);
      rd2(VEC[k][68:64], VEC[k][31:0], VEC[k][31:0], k == 0 ? "R3" : "R1");
    end

    // R6 save direction, R2 wrap on the decrementing instance
    step(1, 0, 0, 0, "R6 save");
    // R5 out 10 aliases in 26 after save
    rd2(5'd26, 32'h0A0A_000A, 32'h0A0A_000A, "R5");
    // R1 global seen from another window
    rd2(5'd1, 32'h1111_0001, 32'h1111_0001, "R1");
    // R4 local privacy
    wr(5'd16, 32'hBBBB_0016);
    rd2(5'd16, 32'hBBBB_0016, 32'hBBBB_0016, "R4");
    step(0, 1, 0, 0, "R6 restore");
    rd2(5'd16, 32'h1616_0010, 32'h1616_0010, "R4");

    // R9 same-cycle bypass, write uses old pointer while a save happens
    @(negedge clk);
    wr_en = 1; wr_idx = 5'd12; wr_val = 32'hC0DE_0012; save_req = 1;
    rd_a_idx = 5'd12; #1;
    check("R9 bypass", a_d, 32'hC0DE_0012); check("R9 bypass", a_i, 32'hC0DE_0012);
    ed = dn(ed); ei = up(ei);
    @(negedge clk); wr_en = 0; save_req = 0;
    rd2(5'd28, 32'hC0DE_0012, 32'hC0DE_0012, "R9 old pointer");
    step(0, 1, 0, 0, "R6 restore");

    // R2 N saves return to start
    for (int k = 0; k < N; k++) step(1, 0, 0, 0, "R2 wrap");
    check("R2 full cycle", 32'(cwp_d), 0); check("R2 full cycle", 32'(cwp_i), 0);

    // R7 blocked save / restore
    inval_mask = 8'b1000_0010;
    step(1, 0, 0, 0, "R7 save blocked");
    step(0, 1, 0, 0, "R7 restore blocked");
    // R8 traps ignore mask and take priority
    step(1, 0, 1, 0, "R8 trap enter");
    step(1, 1, 0, 1, "R8 trap return");
    step(0, 1, 1, 1, "R8 priority");
    inval_mask = '0;
    step(0, 1, 0, 0, "R6 restore");
    // R3 write to zero register ignored
    wr(5'd0, 32'hFFFF_FFFF);
    rd2(5'd0, 0, 0, "R3");

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule